// File: doc/BRIEF.md
# Dual Joystick Port Controller with Beam-Position Latch

This block sits on the I/O bus of an 8-bit processor and serves two joystick ports. Each port has seven lines: up, down, left, right, TL, TR and TH. A single I/O control register sets two things for the TR and TH lines of both ports: whether each line is an input or an output, and the level it drives when it is an output. Two read ports pack the live pin states together with a console-type input and a sticky reset-button flag. When a TR or TH line is set as an output, its read bit returns the programmed level instead of the pin.

When a write to the control register raises either TH output-level bit, the block copies the current horizontal beam counter into a latch and marks the latch valid. This supports light-gun style position sampling. A region-mode input models the domestic-Japan variant, which stores no output levels. A legacy-mode input selects the older reset value of the control register. A memory-control register is kept here as well. Its reset value depends on whether the system boots from internal ROM or from the cartridge, and it can be written.

Top module: `joyport_ctl`

## Requirements
- R1: While reset is held, and afterwards until the first write, the block is in its reset state. `io_ctrl` is 0xFF, or 0xF5 when `legacy_mode` is 1. `mem_ctrl` is 0xE0 when `boot_internal` is 1 and 0xA8 otherwise. `hlatch` is 0, `hlatch_valid` is 0, and bit 4 of the second read port is 1.
- R2: A write with `wr_addr`=1 stores `wr_data` into `io_ctrl` at the next clock edge. Bits 0 to 3 are the directions, where 1 means input. Bits 4 to 7 are the output levels. Within each group the order is A-TR, A-TH, B-TR, B-TH.
- R3: When `region_jp` is 1, a control write stores only bits 3:0 and clears bits 7:4.
- R4: The first read port (`rd_sel`=0) packs its bits as follows. Bits 0 to 4 are port A up, down, left, right and TL, taken from `pa_pins[4:0]`. Bit 5 is port A TR. Bit 6 is port B up (`pb_pins[0]`). Bit 7 is port B down (`pb_pins[1]`). Each pin vector is ordered up, down, left, right, TL, TR, TH from bit 0 to bit 6.
- R5: The second read port (`rd_sel`=1) packs its bits as follows. Bits 0 to 2 are port B left, right and TL. Bit 3 is port B TR. Bit 4 is the inverted sticky press flag. Bit 5 is `cont_in`. Bit 6 is port A TH. Bit 7 is port B TH.
- R6: When a TR or TH line has its direction bit at 0, its read bit shows the matching level bit of `io_ctrl` and ignores the pin.
- R7: A control write that takes bit 5 or bit 7 from 0 in the stored value to 1 in `wr_data` does two things at the next edge: it copies `hcount` into `hlatch` and sets `hlatch_valid`.
- R8: All other cycles leave `hlatch` and `hlatch_valid` unchanged.
- R9: A falling edge on `reset_btn_n`, seen between two consecutive clock samples, sets a sticky press flag. The flag reads as 0 in bit 4 of the second port.
- R10: A read of the second port (`rd_en`=1, `rd_sel`=1) clears the press flag at the next edge, unless a new falling edge arrives in that same cycle. A read of the first port leaves the flag set.
- R11: A write with `wr_addr`=0 stores `wr_data` into `mem_ctrl` and leaves `io_ctrl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| region_jp | input | 1 | Domestic-Japan region mode: level bits are not stored |
| legacy_mode | input | 1 | Selects the legacy reset value of the control register |
| boot_internal | input | 1 | Selects the memory-control reset value for an internal-ROM boot |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 1 = I/O control register, 0 = memory-control register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; its only side effect is on the second port |
| rd_sel | input | 1 | 0 = first read port, 1 = second read port |
| rd_data | output | 8 | Packed read value, combinational |
| pa_pins | input | 7 | Port A pin levels, bits 0 to 6: up, down, left, right, TL, TR, TH |
| pb_pins | input | 7 | Port B pin levels, same order as port A |
| reset_btn_n | input | 1 | Reset button, low when pressed |
| cont_in | input | 1 | Console-type input |
| hcount | input | HCNT_W | Horizontal beam counter |
| io_ctrl | output | 8 | Stored I/O control register |
| mem_ctrl | output | 8 | Stored memory-control register |
| hlatch | output | HCNT_W | Latched beam counter |
| hlatch_valid | output | 1 | Latch holds a captured value |

## Verification
A stale or wrongly masked control value shows up on the very next read. Every TR or TH bit that is set as an output would return a wrong level in the same cycle the read is made, and `io_ctrl` would differ one edge after the write. A wrong compare in the edge detector shows as a `hlatch` value that updates, or fails to update, one edge after the write. A corrupted press flag is only visible through bit 4 of the second port, so the bench reads that port right after each button edge and again after the clearing read.

// File: rtl/joyport_ctl.sv
module joyport_ctl #(
  parameter int HCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              region_jp,
  input  logic              legacy_mode,
  input  logic              boot_internal,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [7:0]        rd_data,
  input  logic [6:0]        pa_pins,
  input  logic [6:0]        pb_pins,
  input  logic              reset_btn_n,
  input  logic              cont_in,
  input  logic [HCNT_W-1:0] hcount,
  output logic [7:0]        io_ctrl,
  output logic [7:0]        mem_ctrl,
  output logic [HCNT_W-1:0] hlatch,
  output logic              hlatch_valid
);
  localparam logic [7:0] CTRL_RST        = 8'hFF;
  localparam logic [7:0] CTRL_RST_LEGACY = 8'hF5;
  localparam logic [7:0] MEM_RST_ROM     = 8'hE0;
  localparam logic [7:0] MEM_RST_CART    = 8'hA8;
  localparam int PIN_TL = 4;
  localparam int PIN_TR = 5;
  localparam int PIN_TH = 6;

  logic [7:0]        ctrl_q, mem_q;
  logic [HCNT_W-1:0] hl_q;
  logic              hl_v_q, btn_prev_q, btn_flag_q;

  wire ctrl_wr  = wr_en & wr_addr;
  wire mem_wr   = wr_en & ~wr_addr;
  wire th_rise  = ctrl_wr & ((~ctrl_q[5] & wr_data[5]) | (~ctrl_q[7] & wr_data[7]));
  wire [7:0] ctrl_d = region_jp ? {4'h0, wr_data[3:0]} : wr_data;
  wire btn_fall = btn_prev_q & ~reset_btn_n;
  wire flag_clr = rd_en & rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= legacy_mode ? CTRL_RST_LEGACY : CTRL_RST;
      mem_q      <= boot_internal ? MEM_RST_ROM : MEM_RST_CART;
      hl_q       <= '0;
      hl_v_q     <= 1'b0;
      btn_prev_q <= 1'b1;
      btn_flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (mem_wr)  mem_q  <= wr_data;
      if (th_rise) begin
        hl_q   <= hcount;
        hl_v_q <= 1'b1;
      end
      btn_prev_q <= reset_btn_n;
      if (btn_fall)      btn_flag_q <= 1'b1;
      else if (flag_clr) btn_flag_q <= 1'b0;
    end
  end

  wire a_tr = ctrl_q[0] ? pa_pins[PIN_TR] : ctrl_q[4];
  wire a_th = ctrl_q[1] ? pa_pins[PIN_TH] : ctrl_q[5];
  wire b_tr = ctrl_q[2] ? pb_pins[PIN_TR] : ctrl_q[6];
  wire b_th = ctrl_q[3] ? pb_pins[PIN_TH] : ctrl_q[7];

  wire [7:0] port_lo = {pb_pins[1], pb_pins[0], a_tr, pa_pins[PIN_TL:0]};
  wire [7:0] port_hi = {b_th, a_th, cont_in, ~btn_flag_q, b_tr, pb_pins[PIN_TL:2]};

  assign rd_data      = rd_sel ? port_hi : port_lo;
  assign io_ctrl      = ctrl_q;
  assign mem_ctrl     = mem_q;
  assign hlatch       = hl_q;
  assign hlatch_valid = hl_v_q;

  a_r3_jp_no_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && region_jp) |=> (io_ctrl[7:4] == 4'h0));

  a_r7_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && ((!io_ctrl[5] && wr_data[5]) || (!io_ctrl[7] && wr_data[7])))
    |=> (hlatch_valid && hlatch == $past(hcount)));

  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr) |=> ($stable(hlatch) && $stable(hlatch_valid)));

  a_r6_a_tr_override: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_ctrl[0] && !rd_sel) |-> (rd_data[5] == io_ctrl[4]));

  a_r10_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && reset_btn_n) |=> !btn_flag_q);

  a_r11_mem_no_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> $stable(io_ctrl));
endmodule

// File: tb/joyport_ctl_tb.sv
`timescale 1ns/1ps
module joyport_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic region_jp = 1'b0, legacy_mode = 1'b0, boot_internal = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [6:0] pa_pins = 7'h7F, pb_pins = 7'h7F;
  logic reset_btn_n = 1'b1, cont_in = 1'b1;
  logic [7:0] hcount = 8'h00;
  logic [7:0] io_ctrl, mem_ctrl, hlatch;
  logic hlatch_valid;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_ctrl, m_mem, m_hl;
  logic m_hv, m_prev, m_flag;

  always #2.5 clk = ~clk;

  joyport_ctl #(.HCNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .region_jp(region_jp), .legacy_mode(legacy_mode),
    .boot_internal(boot_internal), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .pa_pins(pa_pins), .pb_pins(pb_pins),
    .reset_btn_n(reset_btn_n), .cont_in(cont_in), .hcount(hcount), .io_ctrl(io_ctrl),
    .mem_ctrl(mem_ctrl), .hlatch(hlatch), .hlatch_valid(hlatch_valid));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic sel);
    logic atr, ath, btr, bth;
    atr = m_ctrl[0] ? pa_pins[5] : m_ctrl[4];
    ath = m_ctrl[1] ? pa_pins[6] : m_ctrl[5];
    btr = m_ctrl[2] ? pb_pins[5] : m_ctrl[6];
    bth = m_ctrl[3] ? pb_pins[6] : m_ctrl[7];
    if (!sel) return {pb_pins[1], pb_pins[0], atr, pa_pins[4:0]};
    return {bth, ath, cont_in, ~m_flag, btr, pb_pins[4:2]};
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " io_ctrl"}, io_ctrl, m_ctrl);
    chk({tag, " mem_ctrl"}, mem_ctrl, m_mem);
    chk({tag, " hlatch"}, hlatch, m_hl);
    chk({tag, " hlatch_valid"}, {7'd0, hlatch_valid}, {7'd0, m_hv});
  endtask

  task automatic do_reset(input logic jp, input logic leg, input logic boot);
    @(negedge clk);
    rst_n = 1'b0; region_jp = jp; legacy_mode = leg; boot_internal = boot;
    wr_en = 0; rd_en = 0; reset_btn_n = 1'b1;
    m_ctrl = leg ? 8'hF5 : 8'hFF; m_mem = boot ? 8'hE0 : 8'hA8;
    m_hl = 0; m_hv = 0; m_prev = 1; m_flag = 0;
    @(negedge clk); @(negedge clk);
    #1 check_state("R1 reset");
    rd_sel = 1'b1; #0.1 chk("R1 reset button bit", {7'd0, rd_data[4]}, 8'h01);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input string tag, input logic we, input logic wa, input logic [7:0] wd,
                     input logic re, input logic rs);
    logic [7:0] n_ctrl, n_mem, n_hl;
    logic n_hv, n_flag;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_sel = rs;
    #1 chk({tag, " rd_data"}, rd_data, exp_read(rs));
    n_ctrl = m_ctrl; n_mem = m_mem; n_hl = m_hl; n_hv = m_hv; n_flag = m_flag;
    if (we && wa) begin
      if ((!m_ctrl[5] && wd[5]) || (!m_ctrl[7] && wd[7])) begin n_hl = hcount; n_hv = 1; end
      n_ctrl = region_jp ? {4'h0, wd[3:0]} : wd;
    end
    if (we && !wa) n_mem = wd;
    if (re && rs) n_flag = 0;
    if (m_prev && !reset_btn_n) n_flag = 1;
    @(posedge clk);
    m_prev = reset_btn_n;
    m_ctrl = n_ctrl; m_mem = n_mem; m_hl = n_hl; m_hv = n_hv; m_flag = n_flag;
    #1 check_state(tag);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset(0, 0, 1);
    pa_pins = 7'b0101010; pb_pins = 7'b1010101; cont_in = 0;
    cyc("R4 packing port A", 0, 0, 8'h00, 1, 0);
    cyc("R5 packing port B", 0, 0, 8'h00, 1, 1);
    cyc("R2 ctrl write all output low", 1, 1, 8'h00, 0, 0);
    chk("R2 stored value", io_ctrl, 8'h00);
    pa_pins = 7'h7F; pb_pins = 7'h7F;
    cyc("R6 override first port", 0, 0, 8'h00, 0, 0);
    cyc("R6 override second port", 0, 0, 8'h00, 0, 1);
    chk("R6 TH/TR forced low", rd_data & 8'hC8, 8'h00);
    hcount = 8'h5A;
    cyc("R7 latch on A-TH rise", 1, 1, 8'h20, 0, 0);
    chk("R7 latch value", hlatch, 8'h5A);
    hcount = 8'h33;
    cyc("R8 no second latch", 1, 1, 8'h20, 0, 0);
    chk("R8 latch kept", hlatch, 8'h5A);
    cyc("R8 idle", 0, 0, 8'h00, 0, 0);
    hcount = 8'hC4;
    cyc("R7 latch on B-TH rise", 1, 1, 8'hA0, 0, 0);
    chk("R7 latch value B", hlatch, 8'hC4);
    cyc("R11 mem write", 1, 0, 8'h3C, 0, 0);
    chk("R11 mem value", mem_ctrl, 8'h3C);
    reset_btn_n = 0;
    cyc("R9 button press edge", 0, 0, 8'h00, 0, 0);
    reset_btn_n = 1;
    cyc("R9 flag reads pressed", 0, 0, 8'h00, 0, 1);
    chk("R9 bit4 low", {7'd0, rd_data[4]}, 8'h00);
    cyc("R10 first port read keeps flag", 0, 0, 8'h00, 1, 0);
    cyc("R10 second port read", 0, 0, 8'h00, 1, 1);
    cyc("R10 released", 0, 0, 8'h00, 0, 1);
    chk("R10 bit4 high", {7'd0, rd_data[4]}, 8'h01);
    cyc("R10 prep", 0, 0, 8'h00, 0, 0);
    reset_btn_n = 0;
    cyc("R10 edge with read sets", 0, 0, 8'h00, 1, 1);
    reset_btn_n = 1;
    cyc("R10 flag still set", 0, 0, 8'h00, 0, 1);

    do_reset(1, 0, 0);
    hcount = 8'h11;
    cyc("R3 jp write", 1, 1, 8'hF0, 0, 0);
    chk("R3 upper nibble cleared", io_ctrl, 8'h00);
    pa_pins = 7'h7F; pb_pins = 7'h7F;
    cyc("R3 outputs read zero", 0, 0, 8'h00, 0, 1);
    chk("R3 TH bits zero", rd_data & 8'hC8, 8'h00);

    do_reset(0, 1, 1);
    pa_pins = 7'h00; pb_pins = 7'h00;
    cyc("R1 legacy TH reads one", 0, 0, 8'h00, 0, 1);
    chk("R1 legacy TH bits", rd_data & 8'hC0, 8'hC0);

    for (int i = 0; i < 3000; i++) begin
      if (i % 1000 == 0) do_reset(i == 1000, i == 2000, $urandom % 2 == 0);
      pa_pins = 7'($urandom); pb_pins = 7'($urandom);
      cont_in = 1'($urandom); hcount = 8'($urandom);
      reset_btn_n = ($urandom % 6) != 0;
      cyc("R2/R4/R5/R6/R7/R8/R9/R10/R11 random", ($urandom % 3) == 0, 1'($urandom),
          (($urandom % 4) == 0) ? 8'h00 : 8'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule